// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Mailbox

This block joins two processors, called side A and side B, through a set of one-word message slots. Each side has its own register port and its own interrupt line. There are four channels in each direction. A word written to transmit channel n on one side appears in receive channel n on the other side. The flags on both sides then change to match: the sender sees its slot occupied, and the receiver sees a word waiting. When the receiver reads the word, the slot frees up and the sender's empty flag returns.

Each side has a status word and a control word. The status word holds a transmit-empty flag and a receive-full flag for every channel, plus one sticky error bit. The control word holds one interrupt enable for each of those flags. A side raises its interrupt while any enabled flag is set.

The register port never applies back-pressure. A write or read strobe is taken in the cycle it is given, so no ready signal exists. Read data comes back with a valid pulse exactly one cycle after the read strobe. A consumer must take that data in the cycle it appears, because it cannot stall it. The two sides share one clock.

Top module: `mbx_dual_top`

## Requirements
- R1: After reset, each status word reads 0x00F00000 (all transmit-empty flags 1, all receive-full flags 0, sticky bit 0). Each control word reads 0 and both interrupts are low.
- R2: A write to byte offset 4*n (n = 0..3) on one side, while that side's transmit-empty flag n is 1, stores the word for the far side. It also clears the sender's transmit-empty flag n and sets the far side's receive-full flag n.
- R3: A read of byte offset 0x10 + 4*n returns the word held for that side on channel n. It clears that side's receive-full flag n and sets the far side's transmit-empty flag n.
- R4: A transmit write made while the channel's transmit-empty flag is 0 is dropped, and the held word is unchanged. The write sets the sender's sticky error bit, which is status bit 9.
- R5: Writing status (offset 0x20) with bit 9 at 1 clears the sticky bit. Writing it with bit 9 at 0 leaves the sticky bit as it is.
- R6: In the status word at offset 0x20, channel n's transmit-empty flag is bit 20+(3-n) and its receive-full flag is bit 24+(3-n).
- R7: The control word at offset 0x24 keeps only bits 27:20. Bit 20+(3-n) enables transmit-empty n and bit 24+(3-n) enables receive-full n. All other bits read 0.
- R8: A side's interrupt is high exactly while some status flag in bits 27:20 and its matching enable are both 1.
- R9: The status flags other than bit 9 cannot be written. Reads of any other offset return 0, including the transmit offsets and any misaligned address. Writes to such offsets have no effect.
- R10: A read strobe yields a valid pulse with its data in the next cycle and only then.
- R11: The channels and the two directions work independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_addr | input | 6 | Side A byte offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_rvalid | output | 1 | Side A read data valid |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | 6 | Side B byte offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_rvalid | output | 1 | Side B read data valid |
| b_irq | output | 1 | Side B interrupt |

## Verification
The properties assume that the two sides run on the same clock. They also assume that a side does not issue a read and a write in the same cycle, so each slot sees a clean push or a clean pop. The stimulus drives at most one strobe per side per cycle and changes inputs only on falling edges. The properties treat a full slot that nobody pops as frozen. Every stimulus sequence that leaves a slot occupied therefore either reads it or writes it again on purpose, to exercise the dropped-write case.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Byte offsets of the register port
  localparam int unsigned TX_OFS    = 'h00;
  localparam int unsigned RX_OFS    = 'h10;
  localparam int unsigned STAT_OFS  = 'h20;
  localparam int unsigned CTRL_OFS  = 'h24;
  // Flag groups; channel 0 takes the top bit of each group
  localparam int unsigned EMPTY_LSB = 20;
  localparam int unsigned FULL_LSB  = 24;
  localparam int unsigned ERR_BIT   = 9;

  function automatic int unsigned empty_pos(int unsigned ch, int unsigned nch);
    return EMPTY_LSB + (nch - 1 - ch);
  endfunction

  function automatic int unsigned full_pos(int unsigned ch, int unsigned nch);
    return FULL_LSB + (nch - 1 - ch);
  endfunction

  function automatic logic [63:0] flag_mask(int unsigned nch);
    logic [63:0] m;
    m = '0;
    for (int unsigned c = 0; c < nch; c++) begin
      m[empty_pos(c, nch)] = 1'b1;
      m[full_pos(c, nch)]  = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/mbx_slot.sv
// One-word message slot for one channel in one direction.
module mbx_slot #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic          full,
  output logic [DW-1:0] data
);
  logic          full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (push && !full_q) begin
      full_q <= 1'b1;
      data_q <= wdata;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/mbx_port.sv
// Register file, decode and interrupt of one side.
module mbx_port #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  input  logic [NCH-1:0]         tx_full,
  input  logic [NCH-1:0]         rx_full,
  input  logic [NCH-1:0][DW-1:0] rx_data,
  output logic [NCH-1:0]         tx_push,
  output logic [NCH-1:0]         rx_pop,
  output logic [DW-1:0]          rdata,
  output logic                   rvalid,
  output logic                   irq,
  output logic [DW-1:0]          ctrl
);
  import mbx_pkg::*;

  localparam logic [DW-1:0] FLAG_MASK = DW'(flag_mask(NCH));
  localparam logic [AW-1:0] STAT_A    = AW'(STAT_OFS);
  localparam logic [AW-1:0] CTRL_A    = AW'(CTRL_OFS);

  logic [NCH-1:0] tx_hit, rx_hit;
  logic [DW-1:0]  ctrl_q, stat_w, rd_mux, rdata_q;
  logic           err_q, rvalid_q, err_set, err_clr;

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    assign tx_hit[n]  = (addr == AW'(TX_OFS + 4 * n));
    assign rx_hit[n]  = (addr == AW'(RX_OFS + 4 * n));
    assign tx_push[n] = wr_en & tx_hit[n];
    assign rx_pop[n]  = rd_en & rx_hit[n];
  end

  assign err_set = wr_en & |(tx_hit & tx_full);
  assign err_clr = wr_en & (addr == STAT_A) & wdata[ERR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en && addr == CTRL_A) ctrl_q <= wdata & FLAG_MASK;
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_comb begin
    stat_w = '0;
    for (int unsigned n = 0; n < NCH; n++) begin
      stat_w[empty_pos(n, NCH)] = ~tx_full[n];
      stat_w[full_pos(n, NCH)]  = rx_full[n];
    end
    stat_w[ERR_BIT] = err_q;
  end

  always_comb begin
    rd_mux = '0;
    if (addr == STAT_A) rd_mux = stat_w;
    if (addr == CTRL_A) rd_mux = ctrl_q;
    for (int unsigned n = 0; n < NCH; n++)
      if (rx_hit[n]) rd_mux = rx_data[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign irq    = |(stat_w & ctrl_q & FLAG_MASK);
  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
  assign ctrl   = ctrl_q;
endmodule

// File: rtl/mbx_dual_top.sv
module mbx_dual_top #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr_en,
  input  logic          a_rd_en,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_rvalid,
  output logic          a_irq,
  input  logic          b_wr_en,
  input  logic          b_rd_en,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_rvalid,
  output logic          b_irq
);
  logic [NCH-1:0]         ab_full, ba_full;
  logic [NCH-1:0][DW-1:0] ab_data, ba_data;
  logic [NCH-1:0]         a_push, a_pop, b_push, b_pop;
  logic [DW-1:0]          a_ctrl, b_ctrl;

  for (genvar n = 0; n < NCH; n++) begin : g_slot
    mbx_slot #(.DW(DW)) u_ab (
      .clk(clk), .rst_n(rst_n), .push(a_push[n]), .pop(b_pop[n]),
      .wdata(a_wdata), .full(ab_full[n]), .data(ab_data[n]));
    mbx_slot #(.DW(DW)) u_ba (
      .clk(clk), .rst_n(rst_n), .push(b_push[n]), .pop(a_pop[n]),
      .wdata(b_wdata), .full(ba_full[n]), .data(ba_data[n]));
  end

  mbx_port #(.NCH(NCH), .DW(DW), .AW(AW)) u_port_a (
    .clk(clk), .rst_n(rst_n), .wr_en(a_wr_en), .rd_en(a_rd_en),
    .addr(a_addr), .wdata(a_wdata), .tx_full(ab_full), .rx_full(ba_full),
    .rx_data(ba_data), .tx_push(a_push), .rx_pop(a_pop), .rdata(a_rdata),
    .rvalid(a_rvalid), .irq(a_irq), .ctrl(a_ctrl));

  mbx_port #(.NCH(NCH), .DW(DW), .AW(AW)) u_port_b (
    .clk(clk), .rst_n(rst_n), .wr_en(b_wr_en), .rd_en(b_rd_en),
    .addr(b_addr), .wdata(b_wdata), .tx_full(ba_full), .rx_full(ab_full),
    .rx_data(ab_data), .tx_push(b_push), .rx_pop(b_pop), .rdata(b_rdata),
    .rvalid(b_rvalid), .irq(b_irq), .ctrl(b_ctrl));
endmodule

// File: rtl/mbx_dual_chk.sv
module mbx_dual_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   a_wr_en,
  input logic                   a_rd_en,
  input logic [AW-1:0]          a_addr,
  input logic                   a_rvalid,
  input logic                   a_irq,
  input logic                   b_wr_en,
  input logic                   b_rd_en,
  input logic [AW-1:0]          b_addr,
  input logic                   b_rvalid,
  input logic                   b_irq,
  input logic [NCH-1:0]         ab_full,
  input logic [NCH-1:0]         ba_full,
  input logic [NCH-1:0][DW-1:0] ab_data,
  input logic [NCH-1:0][DW-1:0] ba_data,
  input logic [DW-1:0]          a_ctrl,
  input logic [DW-1:0]          b_ctrl
);
  import mbx_pkg::*;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (a_ctrl == '0 && b_ctrl == '0 && ab_full == '0 && ba_full == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    p_ab_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr_en && a_addr == AW'(TX_OFS + 4 * n) && !ab_full[n]) |=> ab_full[n]);
    p_ba_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (b_wr_en && b_addr == AW'(TX_OFS + 4 * n) && !ba_full[n]) |=> ba_full[n]);
    p_ab_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (b_rd_en && b_addr == AW'(RX_OFS + 4 * n) && ab_full[n]) |=> !ab_full[n]);
    p_ba_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd_en && a_addr == AW'(RX_OFS + 4 * n) && ba_full[n]) |=> !ba_full[n]);
    p_ab_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_full[n] && !(b_rd_en && b_addr == AW'(RX_OFS + 4 * n)))
      |=> (ab_full[n] && $stable(ab_data[n])));
    p_ba_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_full[n] && !(a_rd_en && a_addr == AW'(RX_OFS + 4 * n)))
      |=> (ba_full[n] && $stable(ba_data[n])));
  end

  p_a_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ctrl == '0) |-> !a_irq);
  p_b_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (b_ctrl == '0) |-> !b_irq);

  p_a_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    a_rd_en |=> a_rvalid);
  p_a_rquiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rd_en |=> !a_rvalid);
  p_b_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    b_rd_en |=> b_rvalid);
  p_b_rquiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !b_rd_en |=> !b_rvalid);
endmodule

bind mbx_dual_top mbx_dual_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_rvalid(a_rvalid), .a_irq(a_irq),
  .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_rvalid(b_rvalid), .b_irq(b_irq),
  .ab_full(ab_full), .ba_full(ba_full), .ab_data(ab_data), .ba_data(ba_data),
  .a_ctrl(a_ctrl), .b_ctrl(b_ctrl));

// File: tb/sim_mbx_dual_top.sv
module sim_mbx_dual_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_wr_en = 0, a_rd_en = 0, b_wr_en = 0, b_rd_en = 0;
  logic [5:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_rvalid, b_rvalid, a_irq, b_irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbx_dual_top u0 (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_irq(a_irq),
    .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_irq(b_irq));

  // Reference model; direction index = writing side (0 = A, 1 = B)
  bit          m_full [2][4];
  logic [31:0] m_data [2][4];
  logic [31:0] m_ctrl [2];
  bit          m_err  [2];
  localparam logic [31:0] CMASK = 32'h0FF0_0000;

  // Scoreboard queues of expected read words
  logic [31:0] exp_q [2][$];
  string       tag_q [2][$];

  function automatic logic [31:0] m_status(int s);
    logic [31:0] w = '0;
    for (int n = 0; n < 4; n++) begin
      w[20 + 3 - n] = !m_full[s][n];
      w[24 + 3 - n] = m_full[1 - s][n];
    end
    w[9] = m_err[s];
    return w;
  endfunction

  function automatic logic [31:0] m_read(int s, logic [5:0] ad);
    if (ad >= 6'h10 && ad <= 6'h1C && ad[1:0] == 2'b00) return m_data[1 - s][(ad - 6'h10) >> 2];
    if (ad == 6'h20) return m_status(s);
    if (ad == 6'h24) return m_ctrl[s];
    return '0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(int s, logic [5:0] ad, logic [31:0] d);
    @(negedge clk);
    if (s == 0) begin a_wr_en = 1; a_addr = ad; a_wdata = d; end
    else        begin b_wr_en = 1; b_addr = ad; b_wdata = d; end
    if (ad <= 6'h0C && ad[1:0] == 2'b00) begin
      if (!m_full[s][ad >> 2]) begin m_full[s][ad >> 2] = 1; m_data[s][ad >> 2] = d; end
      else m_err[s] = 1;
    end
    if (ad == 6'h20 && d[9]) m_err[s] = 0;
    if (ad == 6'h24) m_ctrl[s] = d & CMASK;
    @(negedge clk);
    a_wr_en = 0; b_wr_en = 0;
  endtask

  task automatic rd(int s, logic [5:0] ad, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q[s].push_back(exp);
    tag_q[s].push_back(tag);
    if (s == 0) begin a_rd_en = 1; a_addr = ad; end
    else        begin b_rd_en = 1; b_addr = ad; end
    if (ad >= 6'h10 && ad <= 6'h1C && ad[1:0] == 2'b00) m_full[1 - s][(ad - 6'h10) >> 2] = 0;
    @(negedge clk);
    a_rd_en = 0; b_rd_en = 0;
  endtask

  task automatic rdm(int s, logic [5:0] ad, string tag);
    rd(s, ad, m_read(s, ad), tag);
  endtask

  task automatic chk_irq(int s, string tag);
    logic exp = |(m_status(s) & m_ctrl[s] & CMASK);
    check(tag, {31'b0, (s == 0) ? a_irq : b_irq}, {31'b0, exp});
  endtask

  // Monitor: pops expected words as read data emerges (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (a_rvalid) begin
        if (exp_q[0].size() == 0) check("R10 unexpected A rvalid", 32'd1, 32'd0);
        else check(tag_q[0].pop_front(), a_rdata, exp_q[0].pop_front());
      end
      if (b_rvalid) begin
        if (exp_q[1].size() == 0) check("R10 unexpected B rvalid", 32'd1, 32'd0);
        else check(tag_q[1].pop_front(), b_rdata, exp_q[1].pop_front());
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      m_ctrl[s] = '0; m_err[s] = 0;
      for (int n = 0; n < 4; n++) begin m_full[s][n] = 0; m_data[s][n] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(0, 6'h20, 32'h00F0_0000, "R1 A status");
    rd(1, 6'h20, 32'h00F0_0000, "R1 B status");
    rd(0, 6'h24, 32'h0, "R1 A ctrl");
    rd(1, 6'h24, 32'h0, "R1 B ctrl");
    @(negedge clk);
    check("R1 A irq", {31'b0, a_irq}, 32'd0);
    check("R1 B irq", {31'b0, b_irq}, 32'd0);

    // R2 / R6 channel 0 A to B
    wr(0, 6'h00, 32'hDEAD_BEEF);
    rd(1, 6'h20, 32'h08F0_0000, "R6 B full0 at bit27");
    rd(0, 6'h20, 32'h0070_0000, "R2 A empty0 cleared");

    // R4 dropped write sets sticky; data intact
    wr(0, 6'h00, 32'h1111_1111);
    rd(0, 6'h20, 32'h0070_0200, "R4 sticky set");
    rd(1, 6'h10, 32'hDEAD_BEEF, "R4 held word unchanged");
    // R3 pop frees the slot
    rd(0, 6'h20, 32'h00F0_0200, "R3 A empty0 back");
    rd(1, 6'h20, 32'h00F0_0000, "R3 B full0 cleared");

    // R5 / R9 write-one-to-clear, other status bits read-only
    wr(0, 6'h20, 32'hFFFF_FDFF);
    rd(0, 6'h20, 32'h00F0_0200, "R5 zero leaves sticky, R9 flags unwritable");
    wr(0, 6'h20, 32'h0000_0200);
    rd(0, 6'h20, 32'h00F0_0000, "R5 sticky cleared");

    // R6 channel 3 B to A
    wr(1, 6'h0C, 32'hCAFE_0003);
    rd(0, 6'h20, 32'h01F0_0000, "R6 A full3 at bit24");
    rd(1, 6'h20, 32'h00E0_0000, "R6 B empty3 at bit20");

    // R7 / R8 control and interrupt
    wr(0, 6'h24, 32'hFFFF_FFFF);
    rd(0, 6'h24, 32'h0FF0_0000, "R7 ctrl mask");
    chk_irq(0, "R8 all enabled");
    wr(0, 6'h24, 32'h0100_0000);
    chk_irq(0, "R8 full3 enabled");
    check("R8 A irq high", {31'b0, a_irq}, 32'd1);
    rd(0, 6'h1C, 32'hCAFE_0003, "R3 A reads ch3");
    chk_irq(0, "R8 drops after pop");
    check("R8 A irq low", {31'b0, a_irq}, 32'd0);
    wr(1, 6'h24, 32'h0010_0000);
    check("R8 B empty3 irq", {31'b0, b_irq}, 32'd1);
    wr(1, 6'h24, 32'h0000_0000);
    check("R8 B irq off", {31'b0, b_irq}, 32'd0);
    wr(0, 6'h24, 32'h0);

    // R9 unused, transmit and misaligned offsets
    rd(0, 6'h28, 32'h0, "R9 unused offset");
    rd(1, 6'h00, 32'h0, "R9 transmit offset reads 0");
    rd(0, 6'h3C, 32'h0, "R9 top offset");
    wr(0, 6'h01, 32'h5555_5555);
    rd(1, 6'h11, 32'h0, "R9 misaligned read");
    rd(1, 6'h20, 32'h00F0_0000, "R9 misaligned write no effect");

    // R11 all channels both directions
    for (int n = 0; n < 4; n++) begin
      wr(0, 6'(4 * n), 32'hA000_0000 + n);
      wr(1, 6'(4 * n), 32'hB000_0000 + n);
    end
    rdm(0, 6'h20, "R11 A status all full");
    rdm(1, 6'h20, "R11 B status all full");
    wr(1, 6'h04, 32'hFFFF_0000);
    rdm(1, 6'h20, "R11 B sticky only");
    for (int n = 3; n >= 0; n--) begin
      rdm(0, 6'(6'h10 + 4 * n), "R11 A receives");
      rdm(1, 6'h20, "R11 B status after pop");
    end
    for (int n = 0; n < 4; n++) rdm(1, 6'(6'h10 + 4 * n), "R11 B receives");
    rdm(0, 6'h20, "R11 A final status");

    // R10 no valid without a read
    @(negedge clk);
    check("R10 quiet A", {31'b0, a_rvalid}, 32'd0);
    check("R10 quiet B", {31'b0, b_rvalid}, 32'd0);
    check("R10 queues drained", exp_q[0].size() + exp_q[1].size(), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule